// File: doc/BRIEF.md
# Configurable-Endian Byte Memory Port

This block is a load/store unit wrapped around a small byte-addressable memory that it owns. A requester presents an address, a transfer size (one, two or four bytes), write data and a direction flag. The unit then moves the quantity through a memory that is one byte wide, so the transfer takes one clock per byte. A mode input picks the byte order. In little-endian order the least significant byte sits at the lowest address. In big-endian order the most significant byte sits there.

The two orders also follow different alignment rules. Big-endian transfers of two or four bytes must start on a boundary that matches their size. Little-endian transfers may start at any byte. Any transfer that would run past the top of the memory is refused in either mode, and so is a reserved size code. A refused request raises a one-cycle fault, touches no memory and returns zero. The byte order is sampled when a request is accepted and holds for the rest of that transfer.

Top module: `endian_byte_port`

## Requirements
- R1: Each of the 1024 byte addresses (10-bit address) holds its own byte. A one-byte transfer (size code 00) writes or reads exactly that byte, using write-data bits 7:0 and returning the byte in read-data bits 7:0.
- R2: With the order input low (little-endian), the byte at start address + k maps to data bits 8k+7:8k, for a size of 2 (code 01) or 4 (code 10) bytes.
- R3: With the order input high (big-endian), the byte at start address + k maps to data bits 8(n-1-k)+7:8(n-1-k), where n is the transfer size in bytes.
- R4: A big-endian four-byte write of 0x12345678 at address 0 leaves bytes 12,34,56,78 at addresses 0..3. The same write in little-endian order leaves 78,56,34,12.
- R5: In big-endian order, a two-byte transfer at an odd address and a four-byte transfer whose address is not a multiple of four are refused.
- R6: In little-endian order, two-byte and four-byte transfers at any start address are carried out, provided they stay inside the memory.
- R7: An accepted transfer keeps busy high for exactly n cycles, beginning the cycle after acceptance. Done then pulses for one cycle with busy low, and read data is valid in that cycle. Unused upper read-data bytes are zero.
- R8: A refused request raises fault and done together for one cycle in the cycle after it is presented. Busy stays low, read data is zero, and no byte of memory changes.
- R9: A transfer whose last byte would lie past address 1023 is refused in both orders, and so is the reserved size code 11.
- R10: Requests presented while busy is high are ignored and write nothing. A change of the order input during a transfer does not affect that transfer.
- R11: After reset, busy, done and fault are low and read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; accepted when busy is low |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 one byte, 01 two bytes, 10 four bytes, 11 reserved |
| req_addr | input | 10 | Start byte address |
| req_wdata | input | 32 | Store data, right-aligned |
| big_endian | input | 1 | Byte order: 1 big-endian, 0 little-endian |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse (also for refusals) |
| fault | output | 1 | One-cycle refusal pulse |
| rdata | output | 32 | Load result, valid while done is high |

## Verification
The hardest situation to reach from the ports is a second request that arrives mid-transfer. It carries a different address and data and comes with the order input flipped. A wrong design could then overwrite memory or remap the lanes of the transfer in flight. The stimulus drives such a request at every busy cycle of chosen transfers, then reads the target byte back. It also reads the transfer's bytes one at a time to confirm the original order held. The top-of-memory boundary is reached with directed transfers at addresses 1020 to 1023 in both orders. A long run of random transfers then sweeps sizes, orders and odd addresses against a byte-level reference model.

// File: rtl/endport_pkg.sv
package endport_pkg;

    localparam int DATA_W = 32;
    localparam int LANES  = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    // Number of bytes moved by a transfer of the given size code.
    function automatic logic [2:0] size_bytes(size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            SZ_WORD: return 3'd4;
            default: return 3'd1;
        endcase
    endfunction

    // Data lane that holds the byte at offset idx of an nb-byte transfer.
    function automatic logic [1:0] lane_of(logic big, logic [2:0] nb, logic [1:0] idx);
        logic [2:0] rev;
        rev = nb - 3'd1 - {1'b0, idx};
        return big ? rev[1:0] : idx;
    endfunction

endpackage

// File: rtl/endport_check.sv
module endport_check
    import endport_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  size_e             size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              big_i,
    output logic              refuse_o
);
    logic [2:0]      nb;
    logic [ADDR_W:0] last_addr;
    logic            misaligned;
    logic            overrun;
    logic            reserved;

    always_comb begin
        nb         = size_bytes(size_i);
        last_addr  = {1'b0, addr_i} + (ADDR_W+1)'(nb) - (ADDR_W+1)'(1);
        overrun    = last_addr[ADDR_W];
        reserved   = (size_i == SZ_RSVD);
        misaligned = 1'b0;
        if (big_i) begin
            if (size_i == SZ_HALF && addr_i[0])
                misaligned = 1'b1;
            if (size_i == SZ_WORD && addr_i[1:0] != 2'b00)
                misaligned = 1'b1;
        end
        refuse_o = misaligned | overrun | reserved;
    end
endmodule

// File: rtl/endport_seq.sv
module endport_seq
    import endport_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              refuse_i,
    input  logic              write_i,
    input  size_e             size_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              big_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fault_o,
    output logic              step_wr_o,
    output logic              step_rd_o,
    output logic [ADDR_W-1:0] step_addr_o,
    output logic [1:0]        step_lane_o
);
    logic              busy_q, done_q, fault_q;
    logic              write_q, big_q;
    logic [1:0]        cnt_q;
    logic [2:0]        nb_q;
    logic [ADDR_W-1:0] base_q;
    logic              last;

    assign last = ({1'b0, cnt_q} == (nb_q - 3'd1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            write_q <= 1'b0;
            big_q   <= 1'b0;
            cnt_q   <= '0;
            nb_q    <= 3'd1;
            base_q  <= '0;
        end else begin
            done_q  <= 1'b0;
            fault_q <= 1'b0;
            if (busy_q) begin
                cnt_q <= cnt_q + 2'd1;
                if (last) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else if (accept_i) begin
                if (refuse_i) begin
                    done_q  <= 1'b1;
                    fault_q <= 1'b1;
                end else begin
                    busy_q  <= 1'b1;
                    cnt_q   <= '0;
                    nb_q    <= size_bytes(size_i);
                    base_q  <= addr_i;
                    write_q <= write_i;
                    big_q   <= big_i;
                end
            end
        end
    end

    assign busy_o      = busy_q;
    assign done_o      = done_q;
    assign fault_o     = fault_q;
    assign step_wr_o   = busy_q & write_q;
    assign step_rd_o   = busy_q & ~write_q;
    assign step_addr_o = base_q + ADDR_W'(cnt_q);
    assign step_lane_o = lane_of(big_q, nb_q, cnt_q);

    // R7: byte counter never passes the transfer length
    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> ({1'b0, cnt_q} < nb_q));
    // R7: busy persists until the final byte
    a_r7_busy_hold: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !last) |=> busy_q);
    // R7: a normal completion is always preceded by a busy cycle
    a_r7_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        (done_q && !fault_q) |-> $past(busy_q));
    // R8: a refusal never overlaps a transfer
    a_r8_fault_idle: assert property (@(posedge clk) disable iff (rst)
        fault_q |-> (done_q && !busy_q));
    // R10: order captured at acceptance stays put
    a_r10_order_stable: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q)) |-> $stable(big_q));
endmodule

// File: rtl/endport_lane.sv
module endport_lane
    import endport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              busy_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              step_rd_i,
    input  logic [1:0]        lane_i,
    input  logic [7:0]        rbyte_i,
    output logic [7:0]        wbyte_o,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [4:0]        bit_base;

    assign bit_base = {lane_i, 3'b000};

    always_ff @(posedge clk) begin
        if (rst) begin
            wdata_q <= '0;
            rdata_q <= '0;
        end else if (!busy_i && accept_i) begin
            wdata_q <= wdata_i;
            rdata_q <= '0;
        end else if (step_rd_i) begin
            rdata_q[bit_base +: 8] <= rbyte_i;
        end
    end

    assign wbyte_o = wdata_q[bit_base +: 8];
    assign rdata_o = rdata_q;
endmodule

// File: rtl/endport_mem.sv
module endport_mem #(
    parameter int ADDR_W = 10,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        wbyte_i,
    output logic [7:0]        rbyte_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i)
            cells[addr_i] <= wbyte_i;
    end

    assign rbyte_o = cells[addr_i];
endmodule

// File: rtl/endian_byte_port.sv
module endian_byte_port
    import endport_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              big_endian,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [31:0]       rdata
);
    size_e             size_c;
    logic              refuse;
    logic              accept;
    logic              step_wr, step_rd;
    logic [ADDR_W-1:0] step_addr;
    logic [1:0]        step_lane;
    logic [7:0]        wbyte, rbyte;

    assign size_c = size_e'(req_size);
    assign accept = req_valid & ~busy;

    endport_check #(.ADDR_W(ADDR_W)) u_check (
        .size_i   (size_c),
        .addr_i   (req_addr),
        .big_i    (big_endian),
        .refuse_o (refuse)
    );

    endport_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .refuse_i    (refuse),
        .write_i     (req_write),
        .size_i      (size_c),
        .addr_i      (req_addr),
        .big_i       (big_endian),
        .busy_o      (busy),
        .done_o      (done),
        .fault_o     (fault),
        .step_wr_o   (step_wr),
        .step_rd_o   (step_rd),
        .step_addr_o (step_addr),
        .step_lane_o (step_lane)
    );

    endport_lane u_lane (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .busy_i    (busy),
        .wdata_i   (req_wdata),
        .step_rd_i (step_rd),
        .lane_i    (step_lane),
        .rbyte_i   (rbyte),
        .wbyte_o   (wbyte),
        .rdata_o   (rdata)
    );

    endport_mem #(.ADDR_W(ADDR_W)) u_mem (
        .clk     (clk),
        .we_i    (step_wr),
        .addr_i  (step_addr),
        .wbyte_i (wbyte),
        .rbyte_o (rbyte)
    );

    // R5: misaligned big-endian word is refused next cycle
    a_r5_be_word_refused: assert property (@(posedge clk) disable iff (rst)
        (accept && big_endian && req_size == 2'b10 && req_addr[1:0] != 2'b00) |=> fault);
    // R6: odd little-endian halfword inside memory is carried out
    a_r6_le_odd_half: assert property (@(posedge clk) disable iff (rst)
        (accept && !big_endian && req_size == 2'b01 && req_addr[0] && req_addr != '1) |=> (busy && !fault));
    // R9: reserved size code is refused
    a_r9_rsvd_refused: assert property (@(posedge clk) disable iff (rst)
        (accept && req_size == 2'b11) |=> fault);
    // R8: a refusal returns zero data
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (rst)
        fault |-> (rdata == 32'd0));
    // R8: memory is only written during a transfer
    a_r8_write_in_busy: assert property (@(posedge clk) disable iff (rst)
        step_wr |-> $past(accept) || $past(busy));
endmodule

// File: tb/endian_byte_port_tb.sv
module endian_byte_port_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = 2'b00;
    logic [9:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        big_endian = 1'b0;
    logic        busy, done, fault;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [7:0] model [1024];

    always #10 clk = ~clk;

    endian_byte_port u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
        .big_endian(big_endian), .busy(busy), .done(done), .fault(fault),
        .rdata(rdata)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 0;
    endfunction

    function automatic bit refused(input logic [1:0] sz, input int addr, input bit be);
        int n = nbytes(sz);
        if (n == 0) return 1'b1;
        if (addr + n > 1024) return 1'b1;
        if (be && n == 2 && addr % 2 != 0) return 1'b1;
        if (be && n == 4 && addr % 4 != 0) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int lane(input bit be, input int n, input int k);
        return be ? (n - 1 - k) : k;
    endfunction

    // One transfer; compares busy/done/fault/rdata each cycle against the model.
    task automatic access(input bit wr, input logic [1:0] sz, input int addr,
                          input logic [31:0] wd, input bit be, input bit poke, input string rq);
        int n = nbytes(sz);
        bit rf = refused(sz, addr, be);
        logic [31:0] exp = '0;
        req_valid = 1'b1; req_write = wr; req_size = sz;
        req_addr = addr[9:0]; req_wdata = wd; big_endian = be;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        if (rf) begin
            chk(fault && done && !busy, rq, {29'd0, busy, done, fault}, 32'd3);
            chk(rdata == 32'd0, rq, rdata, 32'd0);
            return;
        end
        for (int k = 0; k < n; k++) begin
            chk(busy && !done && !fault, {rq, " busy"}, {29'd0, busy, done, fault}, 32'd4);
            if (poke) begin
                req_valid = 1'b1; req_write = 1'b1; req_size = 2'b00;
                req_addr = 10'h3F0; req_wdata = 32'hA5A5A5A5; big_endian = ~be;
            end
            @(posedge clk); @(negedge clk);
        end
        req_valid = 1'b0;
        chk(!busy && done && !fault, {rq, " done"}, {29'd0, busy, done, fault}, 32'd2);
        for (int k = 0; k < n; k++) begin
            int ln = lane(be, n, k);
            if (wr) model[addr + k] = wd[8*ln +: 8];
            else    exp[8*ln +: 8] = model[addr + k];
        end
        if (!wr) chk(rdata == exp, rq, rdata, exp);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R11 reset state
        chk(!busy && !done && !fault && rdata == 0, "R11", {busy, done, fault, rdata[28:0]}, 32'd0);

        // fill memory so the model is known everywhere
        for (int a = 0; a < 1024; a += 4)
            access(1'b1, 2'b10, a, 32'h01020304 * (a + 7) ^ a, 1'b0, 1'b0, "R2 fill");

        // R4 worked example, both orders
        access(1'b1, 2'b10, 0, 32'h12345678, 1'b1, 1'b0, "R4 be write");
        for (int a = 0; a < 4; a++) access(1'b0, 2'b00, a, 0, 1'b0, 1'b0, "R4 be bytes");
        chk(model[0] == 8'h12 && model[3] == 8'h78, "R4 be layout", {model[0], model[3]}, 32'h1278);
        access(1'b1, 2'b10, 8, 32'h12345678, 1'b0, 1'b0, "R4 le write");
        for (int a = 8; a < 12; a++) access(1'b0, 2'b00, a, 0, 1'b1, 1'b0, "R4 le bytes");
        chk(model[8] == 8'h78 && model[11] == 8'h12, "R4 le layout", {model[8], model[11]}, 32'h7812);

        // R2 / R3 cross-order reads and halfwords
        access(1'b0, 2'b10, 0, 0, 1'b0, 1'b0, "R2 le word read");
        access(1'b0, 2'b10, 0, 0, 1'b1, 1'b0, "R3 be word read");
        access(1'b1, 2'b01, 20, 32'h0000BEEF, 1'b1, 1'b0, "R3 be half write");
        access(1'b0, 2'b00, 20, 0, 1'b0, 1'b0, "R3 half msb first");
        access(1'b0, 2'b01, 20, 0, 1'b0, 1'b0, "R2 le half read");

        // R1 single bytes
        access(1'b1, 2'b00, 513, 32'hFFFFFF3C, 1'b1, 1'b0, "R1 byte write");
        access(1'b0, 2'b00, 513, 0, 1'b0, 1'b0, "R1 byte read");

        // R5 big-endian alignment
        access(1'b0, 2'b01, 33, 0, 1'b1, 1'b0, "R5 be odd half");
        access(1'b0, 2'b10, 34, 0, 1'b1, 1'b0, "R5 be word at 2 mod 4");
        access(1'b0, 2'b10, 36, 0, 1'b1, 1'b0, "R5 be aligned word");

        // R6 little-endian odd addresses
        access(1'b1, 2'b10, 45, 32'hCAFEF00D, 1'b0, 1'b0, "R6 le odd word write");
        access(1'b0, 2'b10, 45, 0, 1'b0, 1'b0, "R6 le odd word read");
        access(1'b0, 2'b01, 47, 0, 1'b0, 1'b0, "R6 le odd half");

        // R8 refused write changes nothing
        access(1'b1, 2'b10, 257, 32'hDEADBEEF, 1'b1, 1'b0, "R8 refused write");
        for (int a = 257; a < 261; a++) access(1'b0, 2'b00, a, 0, 1'b0, 1'b0, "R8 bytes unchanged");

        // R9 top-of-memory and reserved size
        access(1'b0, 2'b10, 1021, 0, 1'b0, 1'b0, "R9 le word overrun");
        access(1'b0, 2'b01, 1023, 0, 1'b0, 1'b0, "R9 le half overrun");
        access(1'b0, 2'b10, 1020, 0, 1'b1, 1'b0, "R9 last word ok");
        access(1'b0, 2'b00, 1023, 0, 1'b1, 1'b0, "R9 last byte ok");
        access(1'b0, 2'b11, 100, 0, 1'b0, 1'b0, "R9 reserved size");

        // R10 requests and order flips during busy are ignored
        access(1'b1, 2'b10, 600, 32'h89ABCDEF, 1'b1, 1'b1, "R10 poked write");
        for (int a = 600; a < 604; a++) access(1'b0, 2'b00, a, 0, 1'b0, 1'b0, "R10 order held");
        access(1'b0, 2'b10, 601, 0, 1'b0, 1'b1, "R10 poked read");
        access(1'b0, 2'b00, 10'h3F0, 0, 1'b0, 1'b0, "R10 poke target unchanged");

        // R7 random sweep
        for (int i = 0; i < 500; i++) begin
            logic [1:0] sz = 2'($urandom_range(0, 3));
            int a = int'($urandom_range(0, 1023));
            access(1'($urandom_range(0, 1)), sz, a, $urandom, 1'($urandom_range(0, 1)),
                   1'($urandom_range(0, 3) == 0), "R7 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule